// File: doc/BRIEF.md
# Flash Page Erase and Word Program Sequencer

This block sequences page erase and word program operations on an on-chip flash array. The array is modelled internally as a word-wide memory with one write port and one registered read port. A processor reaches the block through five 32-bit registers: command/status, page select, word select, timing and program data. An erase sweeps every word of the chosen page to all ones. A program operation merges a 32-bit value into one word. Programming can only clear bits.

Each operation runs for a length set by the timing register multiplied by a build-time prescale. While an operation runs, the busy flag is readable and the instruction-fetch read port is stalled. Fetch resumes when the sequencer returns to idle.

If erase and program are requested in the same command write, the erase runs first and the program follows. The block holds the page, word, data and length it captured at the start, so register writes made while busy cannot disturb an operation in flight.

Top module: `flash_page_ctrl`

## Requirements
- R1: After synchronous reset, all registers read 0, `fetch_stall` is low and the sequencer is idle.
- R2: Writing the command register (offset 0) with bit 0 set erases the page given by bits [6:1] of the page-select register (offset 1), leaving every word of that page 0xFFFFFFFF; bits 0 and 7 of the page-select register do not affect which page is chosen.
- R3: An erase leaves every word of every other page unchanged.
- R4: Writing the command register with bit 1 set programs the word at {page, word-select (offset 2) low bits}; the stored value becomes old AND data (offset 4), so a bit is never set by programming.
- R5: With bits 0 and 1 set in the same command write, the page is erased first and the word is then programmed, giving exactly the data value in that word.
- R6: Bit 7 of the command register reads 1 for the whole operation. With T = timing (offset 3) times PRESCALE, busy lasts WPP+T+1 cycles for an erase, T+3 for a program, and the sum of both for a combined request.
- R7: `fetch_stall` is high exactly while busy. When it is low, `fetch_data` returns the word at `fetch_addr` one cycle later.
- R8: A command write while busy is ignored, and changes made to the page, word or data registers while busy do not alter the running operation.
- R9: Command bits 0 and 1 always read back 0; the page, word, timing and data registers read back the value written; register reads are registered (one cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset (0 cmd, 1 page, 2 word, 3 timing, 4 data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| fetch_addr | input | AW (8) | Array word address {page, word} |
| fetch_data | output | 32 | Registered array read data |
| fetch_stall | output | 1 | High while an operation runs |

## Verification
The hardest case to reach is the ordering of a combined request, because a write-then-erase order and an erase-then-write order would both leave plausible-looking pages. The stimulus first programs the target word to zero, then issues erase and program together with a pattern. Only the correct order yields that exact pattern: a missing erase leaves zero, and a reversed order leaves all ones. A second hard case is an ignored command in flight. The bench retargets the page and data registers and issues an erase mid-program, then checks the remaining busy length and both affected pages.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int PAGE_BITS = 6;
  localparam int DW = 32;
  localparam logic [2:0] RA_CMD  = 3'd0;
  localparam logic [2:0] RA_PAGE = 3'd1;
  localparam logic [2:0] RA_WORD = 3'd2;
  localparam logic [2:0] RA_TIME = 3'd3;
  localparam logic [2:0] RA_DATA = 3'd4;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ERASE, ST_EWAIT, ST_WRD, ST_WWR, ST_WWAIT
  } fl_state_e;
endpackage

// File: rtl/fl_regs.sv
module fl_regs #(
  parameter int WORD_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [2:0]           addr,
  input  logic [31:0]          wdata,
  input  logic                 busy,
  output logic [31:0]          rdata,
  output logic                 start_erase,
  output logic                 start_write,
  output logic [5:0]           page_sel,
  output logic [WORD_BITS-1:0] word_sel,
  output logic [7:0]           time_val,
  output logic [31:0]          data_val
);
  import fl_pkg::*;
  logic [7:0] page_q, word_q;
  logic       cmd_hit;

  assign cmd_hit     = we && (addr == RA_CMD) && !busy;
  assign start_erase = cmd_hit && wdata[0];
  assign start_write = cmd_hit && wdata[1];
  assign page_sel    = page_q[6:1];
  assign word_sel    = word_q[WORD_BITS-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q   <= '0;
      word_q   <= '0;
      time_val <= '0;
      data_val <= '0;
      rdata    <= '0;
    end else begin
      if (we) begin
        case (addr)
          RA_PAGE: page_q   <= wdata[7:0];
          RA_WORD: word_q   <= wdata[7:0];
          RA_TIME: time_val <= wdata[7:0];
          RA_DATA: data_val <= wdata;
          default: ;
        endcase
      end
      case (addr)
        RA_CMD:  rdata <= {24'b0, busy, 7'b0};
        RA_PAGE: rdata <= {24'b0, page_q};
        RA_WORD: rdata <= {24'b0, word_q};
        RA_TIME: rdata <= {24'b0, time_val};
        RA_DATA: rdata <= data_val;
        default: rdata <= '0;
      endcase
    end
  end

  // R9
  cmd_read_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == RA_CMD && !$past(rst)) |-> (rdata[6:0] == 7'b0));
endmodule

// File: rtl/fl_array.sv
module fl_array #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fl_seq.sv
module fl_seq #(
  parameter int WPP       = 4,
  parameter int PRESCALE  = 15238,
  parameter int WORD_BITS = 2,
  parameter int AW        = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_erase,
  input  logic                 start_write,
  input  logic [5:0]           page_sel,
  input  logic [WORD_BITS-1:0] word_sel,
  input  logic [7:0]           time_val,
  input  logic [31:0]          data_val,
  input  logic [31:0]          mem_rdata,
  output logic                 busy,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_waddr,
  output logic [31:0]          mem_wdata,
  output logic [AW-1:0]        op_raddr
);
  import fl_pkg::*;
  localparam int CNT_W = 8 + $clog2(PRESCALE + 1);

  fl_state_e            state;
  logic [CNT_W-1:0]     cnt, op_t;
  logic [5:0]           op_page;
  logic [WORD_BITS-1:0] op_word, idx;
  logic [31:0]          op_data;
  logic                 pend_wr;

  assign busy      = (state != ST_IDLE);
  assign mem_we    = (state == ST_ERASE) || (state == ST_WWR);
  assign mem_waddr = {op_page, (state == ST_ERASE) ? idx : op_word};
  assign mem_wdata = (state == ST_ERASE) ? '1 : (mem_rdata & op_data);
  assign op_raddr  = {op_page, op_word};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      op_t    <= '0;
      op_page <= '0;
      op_word <= '0;
      op_data <= '0;
      idx     <= '0;
      pend_wr <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_erase || start_write) begin
          op_page <= page_sel;
          op_word <= word_sel;
          op_data <= data_val;
          op_t    <= CNT_W'(time_val) * CNT_W'(PRESCALE);
          pend_wr <= start_write;
          idx     <= '0;
          state   <= start_erase ? ST_ERASE : ST_WRD;
        end
        ST_ERASE: begin
          idx <= idx + 1'b1;
          if (idx == WORD_BITS'(WPP - 1)) begin
            cnt   <= op_t;
            state <= ST_EWAIT;
          end
        end
        ST_EWAIT: begin
          if (cnt == '0) state <= pend_wr ? ST_WRD : ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_WRD: state <= ST_WWR;
        ST_WWR: begin
          cnt   <= op_t;
          state <= ST_WWAIT;
        end
        ST_WWAIT: begin
          if (cnt == '0) begin
            pend_wr <= 1'b0;
            state   <= ST_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk) $past(rst) |-> (state == ST_IDLE));
  // R5
  erase_then_write_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EWAIT && cnt == '0 && pend_wr) |=> (state == ST_WRD));
  // R6
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EWAIT || state == ST_WWAIT) |-> (cnt <= op_t));
  // R8
  op_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(op_page) && $stable(op_word) && $stable(op_data)));
endmodule

// File: rtl/flash_page_ctrl.sv
module flash_page_ctrl #(
  parameter int WPP      = 4,
  parameter int PRESCALE = 15238,
  localparam int WORD_BITS = $clog2(WPP),
  localparam int AW        = fl_pkg::PAGE_BITS + WORD_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [AW-1:0] fetch_addr,
  output logic [31:0]   fetch_data,
  output logic          fetch_stall
);
  logic                 busy, start_erase, start_write, mem_we;
  logic [5:0]           page_sel;
  logic [WORD_BITS-1:0] word_sel;
  logic [7:0]           time_val;
  logic [31:0]          data_val, mem_wdata, mem_rdata;
  logic [AW-1:0]        mem_waddr, op_raddr, mem_raddr;

  fl_regs #(.WORD_BITS(WORD_BITS)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .rdata(reg_rdata), .start_erase(start_erase),
    .start_write(start_write), .page_sel(page_sel), .word_sel(word_sel),
    .time_val(time_val), .data_val(data_val));

  fl_seq #(.WPP(WPP), .PRESCALE(PRESCALE), .WORD_BITS(WORD_BITS), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start_erase(start_erase), .start_write(start_write),
    .page_sel(page_sel), .word_sel(word_sel), .time_val(time_val),
    .data_val(data_val), .mem_rdata(mem_rdata), .busy(busy), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .op_raddr(op_raddr));

  assign mem_raddr = busy ? op_raddr : fetch_addr;

  fl_array #(.AW(AW), .DW(32)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata));

  assign fetch_data  = mem_rdata;
  assign fetch_stall = busy;

  // R7
  write_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> fetch_stall);
endmodule

// File: tb/tb_flash_page_ctrl.sv
module tb_flash_page_ctrl;
  localparam int CLK_NS = 10;
  localparam int WPP = 4;
  localparam int PRE = 2;
  localparam int TIMEV = 3;
  localparam int T = TIMEV * PRE;
  localparam int LEN_ER = WPP + T + 1;
  localparam int LEN_WR = T + 3;

  typedef struct { logic [7:0] a; logic [31:0] v; string tag; } item_t;

  logic clk = 0, rst = 1, reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, fetch_data;
  logic [7:0] fetch_addr = 0;
  logic fetch_stall;
  int total = 0, bad = 0;
  bit mon_active = 0, finished = 0;
  item_t q[$];
  logic [31:0] model [256];

  always #(CLK_NS/2) clk = ~clk;

  flash_page_ctrl #(.WPP(WPP), .PRESCALE(PRE)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_addr(fetch_addr),
    .fetch_data(fetch_data), .fetch_stall(fetch_stall));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic op(input int pg, input int w, input logic [31:0] d, input logic [31:0] cmd,
                    input int exp_len, input string tag);
    int n;
    wr(3'd1, 32'(pg << 1));
    wr(3'd2, 32'(w));
    wr(3'd4, d);
    wr(3'd0, cmd);
    n = 0;
    while (fetch_stall) begin n++; @(negedge clk); end
    check(n == exp_len, {tag, " busy length"}, 32'(n), 32'(exp_len));
    if (cmd[0]) for (int i = 0; i < WPP; i++) model[pg*WPP+i] = '1;
    if (cmd[1]) model[pg*WPP+w] = model[pg*WPP+w] & d;
  endtask

  task automatic verify_page(input int pg, input string tag);
    for (int i = 0; i < WPP; i++) begin
      item_t it;
      it.a = 8'(pg*WPP+i); it.v = model[pg*WPP+i]; it.tag = tag;
      q.push_back(it);
    end
    while (q.size() != 0 || mon_active) @(negedge clk);
  endtask

  // monitor: pops expected items and compares the fetch port
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() != 0 && !fetch_stall) begin
        item_t it;
        mon_active = 1;
        it = q.pop_front();
        fetch_addr = it.a;
        @(negedge clk);
        check(fetch_data === it.v, {it.tag, " R7 fetch word"}, fetch_data, it.v);
        mon_active = 0;
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int r;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(fetch_stall == 0, "R1 stall after reset", 32'(fetch_stall), 0);
    rd(3'd0, d); check(d == 0, "R1 cmd after reset", d, 0);
    rd(3'd4, d); check(d == 0, "R1 data after reset", d, 0);
    // R9 readback
    wr(3'd3, TIMEV); rd(3'd3, d); check(d == TIMEV, "R9 timing readback", d, TIMEV);
    wr(3'd4, 32'hCAFE_F00D); rd(3'd4, d); check(d == 32'hCAFE_F00D, "R9 data readback", d, 32'hCAFE_F00D);
    // R2 / R6 erases
    op(4, 0, 0, 1, LEN_ER, "R6 erase");
    op(5, 0, 0, 1, LEN_ER, "R6 erase");
    op(6, 0, 0, 1, LEN_ER, "R6 erase");
    verify_page(4, "R2 erased page");
    // R4 programming clears bits only
    op(4, 1, 32'h1234_5678, 2, LEN_WR, "R6 program");
    op(4, 1, 32'hFFFF_0000, 2, LEN_WR, "R4 program");
    op(6, 3, 32'hA5A5_A5A5, 2, LEN_WR, "R4 program");
    op(5, 2, 32'h0, 2, LEN_WR, "R4 program");
    verify_page(4, "R4 and-merge");
    verify_page(5, "R4 zero word");
    // R5 combined request: erase first, then program
    op(5, 2, 32'h0F0F_0F0F, 3, LEN_ER + LEN_WR, "R5 combined");
    verify_page(5, "R5 order");
    // R2 extra page-select bits ignored, R3 neighbours untouched
    wr(3'd1, 32'h8B);
    wr(3'd0, 1);
    while (fetch_stall) @(negedge clk);
    for (int i = 0; i < WPP; i++) model[5*WPP+i] = '1;
    verify_page(5, "R2 page select bits");
    verify_page(4, "R3 neighbour below");
    verify_page(6, "R3 neighbour above");
    // R6 busy bit, R7 stall, R9 start bits self-clear
    wr(3'd1, 32'(5 << 1));
    wr(3'd0, 1);
    rd(3'd0, d); check(d == 32'h80, "R6 busy bit during erase", d, 32'h80);
    check(fetch_stall == 1, "R7 stall during erase", 32'(fetch_stall), 1);
    while (fetch_stall) @(negedge clk);
    rd(3'd0, d); check(d == 0, "R9 cmd after completion", d, 0);
    // R8 ignored command and register changes in flight
    wr(3'd1, 32'(4 << 1)); wr(3'd2, 0); wr(3'd4, 32'h00FF_00FF);
    wr(3'd0, 2);
    wr(3'd4, 0); wr(3'd1, 32'(6 << 1)); wr(3'd0, 1);
    r = 0;
    while (fetch_stall) begin r++; @(negedge clk); end
    check(r == LEN_WR - 6, "R8 remaining busy", 32'(r), 32'(LEN_WR - 6));
    model[4*WPP] = model[4*WPP] & 32'h00FF_00FF;
    verify_page(4, "R8 latched data");
    verify_page(6, "R8 erase ignored");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule